// File: doc/BRIEF.md
# Unrolled Double SHA-256 Nonce Search Pipeline

This block searches a range of 32-bit nonces for a block header whose double SHA-256 has a zero final word. Each round of each compression is its own register stage, so once the pipe is full, one new nonce enters and one result leaves on every clock. The host side loads a per-range context: the 256-bit midstate left by the first header block, the three header words that precede the nonce in the second block, and the working variables after the first few rounds of the second-block compression. Those opening rounds do not depend on the nonce, so they are computed outside the block and not built here.

After a load, the block drives its own nonce counter from a start value. Each nonce passes through the remaining first-hash rounds, the midstate addition, a padded second-hash message, and a second compression that is cut short at the round that fixes the final output word. A comparator tests the low bits of that word and flags a hit together with the nonce that produced it. The nonce is not carried down the pipe: it is rebuilt from the free-running counter minus the fixed latency.

Top module: `dsha_search_pipe`

## Requirements
- R1: While rst_ni is low, and after reset until the first load, valid_o and found_o stay low.
- R2: If load_i is sampled high at clock edge L, the result for the start nonce is presented with valid_o high after edge L+123 (with SKIP_ROUNDS = 3). A new result follows on every clock while nonces remain in the range.
- R3: h7_o is word 7 of the second compression. The first compression starts from mid_i (word i in bits 32i+31:32i) over W0, W1 and W2 from head_w_i bits 31:0, 63:32 and 95:64, then W3 = nonce, W4 = 0x80000000, W5 to W14 = 0 and W15 = 640. Its digest is the midstate plus the compression result. The second compression starts from the standard SHA-256 initial value over digest words 0 to 7, then 0x80000000, six zero words and 256. state_i holds the working variables a to h (a in bits 31:0) after rounds 0 to SKIP_ROUNDS-1 of the first compression.
- R4: found_o is high exactly when valid_o is high and h7_o[HIT_BITS-1:0] is zero.
- R5: The first nonce after a load is start_nonce_i. Each following nonce is one more than the one before. nonce_o gives the nonce of the result presented in the same cycle.
- R6: Once nonce 0xFFFFFFFF has been issued, no further nonce is issued. valid_o falls in the cycle after that nonce's result and stays low until the next load.
- R7: A load flushes the pipe. From the edge that samples load_i until the first result of the new range, valid_o and found_o are low, and no result of the old range ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load a new range context and flush the pipe |
| start_nonce_i | input | 32 | First nonce of the range |
| mid_i | input | 256 | Midstate after the first header block |
| state_i | input | 256 | Working variables after the skipped opening rounds |
| head_w_i | input | 96 | Second-block message words W0 to W2 |
| valid_o | output | 1 | A result is presented this cycle |
| found_o | output | 1 | The presented result is a hit |
| nonce_o | output | 32 | Nonce of the presented result |
| h7_o | output | 32 | Final word of the double hash for that nonce |

## Verification
The bench builds the block with HIT_BITS = 4 and the default SKIP_ROUNDS = 3. With the full 32-bit hit test, a hit would almost never occur in a short run. With four bits, about one result in sixteen is a hit, so the found path and the nonce reported with it are exercised many times. A range that starts 96 nonces below the wrap point reaches the end-of-range stop within the run. A reload that lands while the pipe is only partly filled checks the flush at the point where old and new results would otherwise mix.

// File: rtl/dsha_pkg.sv
package dsha_pkg;
  typedef logic [31:0] word_t;
  typedef word_t [7:0]  st_t;   // [0] = a ... [7] = h
  typedef word_t [15:0] win_t;  // schedule window, [0] oldest

  localparam word_t PAD_WORD = 32'h8000_0000;
  localparam word_t LEN_HDR  = 32'd640;
  localparam word_t LEN_DIG  = 32'd256;

  localparam st_t IV_ST = {32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
                           32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667};

  function automatic word_t rotr(word_t x, int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic word_t bsig0(word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t bsig1(word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t ssig0(word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t ssig1(word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t k_of(int t);
    case (t)
      0:  return 32'h428a2f98;  1: return 32'h71374491;  2: return 32'hb5c0fbcf;  3: return 32'he9b5dba5;
      4:  return 32'h3956c25b;  5: return 32'h59f111f1;  6: return 32'h923f82a4;  7: return 32'hab1c5ed5;
      8:  return 32'hd807aa98;  9: return 32'h12835b01; 10: return 32'h243185be; 11: return 32'h550c7dc3;
      12: return 32'h72be5d74; 13: return 32'h80deb1fe; 14: return 32'h9bdc06a7; 15: return 32'hc19bf174;
      16: return 32'he49b69c1; 17: return 32'hefbe4786; 18: return 32'h0fc19dc6; 19: return 32'h240ca1cc;
      20: return 32'h2de92c6f; 21: return 32'h4a7484aa; 22: return 32'h5cb0a9dc; 23: return 32'h76f988da;
      24: return 32'h983e5152; 25: return 32'ha831c66d; 26: return 32'hb00327c8; 27: return 32'hbf597fc7;
      28: return 32'hc6e00bf3; 29: return 32'hd5a79147; 30: return 32'h06ca6351; 31: return 32'h14292967;
      32: return 32'h27b70a85; 33: return 32'h2e1b2138; 34: return 32'h4d2c6dfc; 35: return 32'h53380d13;
      36: return 32'h650a7354; 37: return 32'h766a0abb; 38: return 32'h81c2c92e; 39: return 32'h92722c85;
      40: return 32'ha2bfe8a1; 41: return 32'ha81a664b; 42: return 32'hc24b8b70; 43: return 32'hc76c51a3;
      44: return 32'hd192e819; 45: return 32'hd6990624; 46: return 32'hf40e3585; 47: return 32'h106aa070;
      48: return 32'h19a4c116; 49: return 32'h1e376c08; 50: return 32'h2748774c; 51: return 32'h34b0bcb5;
      52: return 32'h391c0cb3; 53: return 32'h4ed8aa4a; 54: return 32'h5b9cca4f; 55: return 32'h682e6ff3;
      56: return 32'h748f82ee; 57: return 32'h78a5636f; 58: return 32'h84c87814; 59: return 32'h8cc70208;
      60: return 32'h90befffa; 61: return 32'ha4506ceb; 62: return 32'hbef9a3f7; 63: return 32'hc67178f2;
      default: return 32'h0;
    endcase
  endfunction

  function automatic st_t sha_round(st_t s, word_t k, word_t w);
    word_t t1, t2;
    st_t   r;
    t1 = s[7] + bsig1(s[4]) + ((s[4] & s[5]) ^ (~s[4] & s[6])) + k + w;
    t2 = bsig0(s[0]) + ((s[0] & s[1]) ^ (s[0] & s[2]) ^ (s[1] & s[2]));
    r[0] = t1 + t2;
    r[1] = s[0];
    r[2] = s[1];
    r[3] = s[2];
    r[4] = s[3] + t1;
    r[5] = s[4];
    r[6] = s[5];
    r[7] = s[6];
    return r;
  endfunction

  function automatic word_t sched_next(win_t w);
    return ssig1(w[14]) + w[9] + ssig0(w[1]) + w[0];
  endfunction
endpackage

// File: rtl/dsha_round_stage.sv
module dsha_round_stage
  import dsha_pkg::*;
#(
  parameter int ROUND = 0,
  parameter int SLOT  = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic vld_i,
  input  st_t  st_i,
  input  win_t win_i,
  output logic vld_o,
  output st_t  st_o,
  output win_t win_o
);
  localparam word_t K_T = k_of(ROUND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_o <= 1'b0;
    else if (flush_i) vld_o <= 1'b0;
    else              vld_o <= vld_i;
  end

  // datapath flops carry no reset; validity travels in vld_o
  always_ff @(posedge clk_i) begin
    st_o  <= sha_round(st_i, K_T, win_i[SLOT]);
    win_o <= {sched_next(win_i), win_i[15:1]};
  end
endmodule

// File: rtl/dsha_nonce_ctr.sv
module dsha_nonce_ctr (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [31:0] start_i,
  output logic [31:0] cnt_o,
  output logic        live_o
);
  // counter free-runs so the output nonce can be rebuilt by subtraction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      live_o <= 1'b0;
    end else if (load_i) begin
      cnt_o  <= start_i;
      live_o <= 1'b1;
    end else begin
      cnt_o <= cnt_o + 32'd1;
      if (live_o && (cnt_o == 32'hFFFF_FFFF)) live_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dsha_hit_cmp.sv
module dsha_hit_cmp
  import dsha_pkg::*;
#(
  parameter int          HIT_BITS = 32,
  parameter logic [31:0] BACK     = 32'd122
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flush_i,
  input  logic        vld_i,
  input  word_t       e_i,
  input  logic [31:0] cnt_i,
  output logic        valid_o,
  output logic        found_o,
  output logic [31:0] nonce_o,
  output logic [31:0] h7_o
);
  word_t h7;
  logic  zero;

  // final h after 64 rounds equals e after round 60
  assign h7   = e_i + IV_ST[7];
  assign zero = (h7[HIT_BITS-1:0] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      found_o <= 1'b0;
      nonce_o <= '0;
      h7_o    <= '0;
    end else begin
      valid_o <= vld_i && !flush_i;
      found_o <= vld_i && !flush_i && zero;
      nonce_o <= cnt_i - BACK;
      h7_o    <= h7;
    end
  end
endmodule

// File: rtl/dsha_search_pipe.sv
module dsha_search_pipe
  import dsha_pkg::*;
#(
  parameter int SKIP_ROUNDS = 3,
  parameter int HIT_BITS    = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [31:0]  start_nonce_i,
  input  logic [255:0] mid_i,
  input  logic [255:0] state_i,
  input  logic [95:0]  head_w_i,
  output logic         valid_o,
  output logic         found_o,
  output logic [31:0]  nonce_o,
  output logic [31:0]  h7_o
);
  localparam int N1  = 64 - SKIP_ROUNDS;
  localparam int N2  = 61;
  localparam int LAT = N1 + N2 + 1;
  localparam logic [31:0] BACK = 32'(N1 + N2);

  st_t         ctx_st, ctx_mid;
  logic [95:0] ctx_hw;
  logic [31:0] cnt;
  logic        live;

  always_ff @(posedge clk_i) begin
    if (load_i) begin
      ctx_st  <= state_i;
      ctx_mid <= mid_i;
      ctx_hw  <= head_w_i;
    end
  end

  dsha_nonce_ctr u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .start_i (start_nonce_i),
    .cnt_o   (cnt),
    .live_o  (live)
  );

  logic a_vld [N1+1];
  st_t  a_st  [N1+1];
  win_t a_win [N1+1];
  logic b_vld [N2+1];
  st_t  b_st  [N2+1];
  win_t b_win [N2+1];
  win_t a_win0, b_win0;

  always_comb begin
    a_win0     = '0;
    a_win0[0]  = ctx_hw[31:0];
    a_win0[1]  = ctx_hw[63:32];
    a_win0[2]  = ctx_hw[95:64];
    a_win0[3]  = cnt;
    a_win0[4]  = PAD_WORD;
    a_win0[15] = LEN_HDR;
  end

  assign a_vld[0] = live;
  assign a_st[0]  = ctx_st;
  assign a_win[0] = a_win0;

  for (genvar i = 0; i < N1; i++) begin : g_h1
    dsha_round_stage #(.ROUND(SKIP_ROUNDS + i), .SLOT(SKIP_ROUNDS)) u_rnd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (load_i),
      .vld_i   (a_vld[i]),
      .st_i    (a_st[i]),
      .win_i   (a_win[i]),
      .vld_o   (a_vld[i+1]),
      .st_o    (a_st[i+1]),
      .win_o   (a_win[i+1])
    );
  end

  // midstate add feeds the second message directly
  always_comb begin
    b_win0 = '0;
    for (int i = 0; i < 8; i++) b_win0[i] = a_st[N1][i] + ctx_mid[i];
    b_win0[8]  = PAD_WORD;
    b_win0[15] = LEN_DIG;
  end

  assign b_vld[0] = a_vld[N1];
  assign b_st[0]  = IV_ST;
  assign b_win[0] = b_win0;

  for (genvar i = 0; i < N2; i++) begin : g_h2
    dsha_round_stage #(.ROUND(i), .SLOT(0)) u_rnd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (load_i),
      .vld_i   (b_vld[i]),
      .st_i    (b_st[i]),
      .win_i   (b_win[i]),
      .vld_o   (b_vld[i+1]),
      .st_o    (b_st[i+1]),
      .win_o   (b_win[i+1])
    );
  end

  dsha_hit_cmp #(.HIT_BITS(HIT_BITS), .BACK(BACK)) u_hit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (load_i),
    .vld_i   (b_vld[N2]),
    .e_i     (b_st[N2][4]),
    .cnt_i   (cnt),
    .valid_o (valid_o),
    .found_o (found_o),
    .nonce_o (nonce_o),
    .h7_o    (h7_o)
  );
endmodule

// File: rtl/dsha_search_chk.sv
module dsha_search_chk #(
  parameter int HIT_BITS = 32,
  parameter int LAT      = 123
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        load_i,
  input logic        valid_o,
  input logic        found_o,
  input logic [31:0] nonce_o,
  input logic [31:0] h7_o
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] LAT_C = CW'(LAT);

  logic [CW-1:0] since_ld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_ld <= '0;
    else if (load_i)           since_ld <= '0;
    else if (since_ld != LAT_C) since_ld <= since_ld + 1'b1;
  end

  p_quiet_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_ld < LAT_C) |-> !valid_o);

  p_found_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> valid_o);

  p_found_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (h7_o[HIT_BITS-1:0] == '0));

  p_nonce_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |-> (nonce_o == $past(nonce_o) + 32'd1));

  p_range_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && nonce_o == 32'hFFFF_FFFF) |=> !valid_o);

  p_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!valid_o && !found_o));
endmodule

bind dsha_search_pipe dsha_search_chk #(.HIT_BITS(HIT_BITS), .LAT(LAT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_i  (load_i),
  .valid_o (valid_o),
  .found_o (found_o),
  .nonce_o (nonce_o),
  .h7_o    (h7_o)
);

// File: tb/sim_dsha_search_pipe.sv
`timescale 1ns/1ps
module sim_dsha_search_pipe;
  localparam int HB  = 4;
  localparam int LAT = (64 - 3) + 61 + 1;

  typedef logic [7:0][31:0]  h8_t;
  typedef logic [15:0][31:0] m16_t;
  typedef struct {
    bit          v;
    int          c;
    logic [31:0] n;
    string       tag;
  } rec_t;

  localparam logic [31:0] KT [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  localparam h8_t IV = {32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
                        32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667};

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         load_i;
  logic [31:0]  start_nonce_i;
  logic [255:0] mid_i, state_i;
  logic [95:0]  head_w_i;
  logic         valid_o, found_o;
  logic [31:0]  nonce_o, h7_o;

  int n_chk = 0, n_fail = 0, n_hit = 0;
  bit done = 0;

  h8_t         cmid [4];
  h8_t         cst  [4];
  logic [95:0] chw  [4];

  rec_t        q [$];
  logic [31:0] mcnt = 0;
  bit          mlive = 0, loaded = 0;
  int          mctx = 0;

  always #10 clk_i = ~clk_i;

  dsha_search_pipe #(.SKIP_ROUNDS(3), .HIT_BITS(HB)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .start_nonce_i(start_nonce_i),
    .mid_i(mid_i), .state_i(state_i), .head_w_i(head_w_i),
    .valid_o(valid_o), .found_o(found_o), .nonce_o(nonce_o), .h7_o(h7_o)
  );

  function automatic logic [31:0] rr(logic [31:0] x, int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic h8_t run_rounds(h8_t s, m16_t m, int n);
    logic [31:0] w [64];
    logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
    h8_t r;
    for (int i = 0; i < 16; i++) w[i] = m[i];
    for (int i = 16; i < 64; i++)
      w[i] = (rr(w[i-2], 17) ^ rr(w[i-2], 19) ^ (w[i-2] >> 10)) + w[i-7]
           + (rr(w[i-15], 7) ^ rr(w[i-15], 18) ^ (w[i-15] >> 3)) + w[i-16];
    a = s[0]; b = s[1]; c = s[2]; d = s[3]; e = s[4]; f = s[5]; g = s[6]; h = s[7];
    for (int t = 0; t < n; t++) begin
      t1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + KT[t] + w[t];
      t2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
      h = g; g = f; f = e; e = d + t1; d = c; c = b; b = a; a = t1 + t2;
    end
    r = {h, g, f, e, d, c, b, a};
    return r;
  endfunction

  function automatic h8_t compress(h8_t s, m16_t m);
    h8_t r;
    r = run_rounds(s, m, 64);
    for (int i = 0; i < 8; i++) r[i] = r[i] + s[i];
    return r;
  endfunction

  function automatic m16_t hdr_msg(logic [95:0] hw, logic [31:0] nonce);
    m16_t m = '0;
    m[0] = hw[31:0]; m[1] = hw[63:32]; m[2] = hw[95:64];
    m[3] = nonce; m[4] = 32'h8000_0000; m[15] = 32'd640;
    return m;
  endfunction

  function automatic logic [31:0] ref_h7(int c, logic [31:0] nonce);
    h8_t  d, r;
    m16_t m2 = '0;
    d = compress(cmid[c], hdr_msg(chw[c], nonce));
    for (int i = 0; i < 8; i++) m2[i] = d[i];
    m2[8] = 32'h8000_0000; m2[15] = 32'd256;
    r = compress(IV, m2);
    return r[7];
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit ld, int c, logic [31:0] st);
    rec_t        r;
    logic [31:0] e;
    load_i = ld;
    if (ld) begin
      mid_i = cmid[c]; state_i = cst[c]; head_w_i = chw[c]; start_nonce_i = st;
    end
    @(posedge clk_i);
    if (ld) begin
      foreach (q[i]) begin q[i].v = 0; q[i].tag = "R7"; end
      mcnt = st; mlive = 1; mctx = c; loaded = 1;
    end else begin
      if (mlive && mcnt == 32'hFFFF_FFFF) mlive = 0;
      mcnt = mcnt + 32'd1;
    end
    q.push_back('{mlive, mctx, mcnt, loaded ? "R6" : "R1"});
    @(negedge clk_i);
    load_i = 1'b0;
    if (q.size() > LAT) r = q.pop_front();
    else r = '{0, 0, 32'd0, "R1"};
    if (!r.v) begin
      chk(!valid_o && !found_o, r.tag, {30'd0, valid_o, found_o}, 32'd0);
    end else begin
      e = ref_h7(r.c, r.n);
      chk(valid_o === 1'b1, "R2", {31'd0, valid_o}, 32'd1);
      chk(h7_o === e, "R3", h7_o, e);
      chk(found_o === (e[HB-1:0] == '0), "R4", {31'd0, found_o}, {31'd0, e[HB-1:0] == '0});
      chk(nonce_o === r.n, "R5", nonce_o, r.n);
      if (found_o) n_hit++;
    end
  endtask

  initial begin
    rst_ni = 1'b0; load_i = 1'b0; start_nonce_i = '0;
    mid_i = '0; state_i = '0; head_w_i = '0;
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 8; i++) cmid[c][i] = $urandom;
      chw[c] = {$urandom, $urandom, $urandom};
      cst[c] = run_rounds(cmid[c], hdr_msg(chw[c], 32'd0), 3);
    end
    repeat (3) begin
      @(negedge clk_i);
      chk(!valid_o && !found_o, "R1", {30'd0, valid_o, found_o}, 32'd0);
    end
    rst_ni = 1'b1;
    repeat (5) step(0, 0, 0);
    step(1, 0, 32'h0000_1000);
    repeat (250) step(0, 0, 0);
    step(1, 1, 32'hFFFF_FFA0);      // reload mid-stream, range near wrap
    repeat (300) step(0, 0, 0);
    step(1, 2, 32'h0000_0007);
    repeat (20) step(0, 0, 0);
    step(1, 3, 32'h8000_0000);      // reload with pipe partly filled
    repeat (200) step(0, 0, 0);
    chk(n_hit > 0, "R4 hits seen", n_hit, 32'd1);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule